// File: doc/BRIEF.md
# Byte-wide NOR flash program and erase sequencer

This block sits on the host side of an asynchronous, byte-wide NOR flash bus. A request names an operation (read, byte program, sector erase or whole-chip erase), a target address and a data byte. The sequencer then turns that request into bus traffic on the flash pins. For a write-type operation it issues the unlock and command write cycles in the required order. Each write strobe is timed from the system clock, with widths given in nanoseconds. After the last strobe it polls the flash with repeated reads until DQ6 stops toggling.

Once toggling stops, the sequencer makes one more read and compares the byte with the value the operation should have left. That value is the programmed byte for a program and FFh for an erase. A mismatch raises `err`. If polling runs past a limit, which differs for program and erase, the sequencer writes F0h to put the flash back in read mode and raises `err`. A read request is a single timed read cycle. Every request ends with a one-clock `done` pulse.

The flash data bus is split into an output byte, an input byte and a drive enable, so that pad logic outside the block can form the tri-state pin.

Top module: `flash_cmd_seq`

## Requirements
- R1: A program request (`req_op` = 1) issues exactly four write cycles, as address/data pairs: 555h/AAh, 2AAh/55h, 555h/A0h, then `req_addr`/`req_data`.
- R2: An erase request issues exactly six write cycles: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then a final cycle. For a sector erase (`req_op` = 2) the final cycle is `req_addr`/30h. For a chip erase (`req_op` = 3) it is 555h/10h.
- R3: Every write strobe is low for at least T_WP_NS (50 ns) and high for at least T_WPH_NS (30 ns) between pulses. Successive falling edges are at least T_WC_NS (100 ns) apart. Address and output data do not change while the strobe is low.
- R4: Output enable is never low while the write strobe is low. The data drive enable is high whenever the write strobe is low.
- R5: Polling starts only after the last command strobe and reads the target address. Polling ends when two consecutive reads show the same DQ6. The sequencer then makes one more read, returns that byte on `rd_data`, and sets `err` when it differs from `req_data` (program) or from FFh (erase).
- R6: Polling is bounded by PROG_TMO_CYC clock cycles for a program and by ERASE_TMO_CYC for an erase. When the limit is reached, a final write of F0h is issued, then `done` is raised with `err` set.
- R7: A read request (`req_op` = 0) performs one read cycle with output enable low for at least T_RC_NS. It makes no write cycle, returns the byte on `rd_data`, and clears `err`.
- R8: `busy` is high from the cycle after an accepted `req_start` until `done`. `req_start` has no effect while `busy` is high. `done` is high for exactly one clock per request.
- R9: Out of reset, chip enable, output enable and write strobe are high, the data drive enable is low, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | ADDR_W | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Verify mismatch or timeout of the last request |
| rd_data | output | 8 | Byte from the read request or the final verify read |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Byte driven onto the flash data bus |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Byte read from the flash data bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |

## Verification
The assertions depend on reset being held low for at least one edge before use. They do not depend on any particular protocol on `req_start`. The bench deliberately pulses `req_start` in the middle of a request to show that it is ignored.

The bench never lets `fl_dq_in` change during an output-enable pulse, except at its falling edge, where its flash model advances the toggle state. This keeps the sampled byte well defined. Request inputs are changed only on the falling clock edge.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W = 21,
  parameter int CLK_NS = 8,
  parameter int T_WP_NS = 50,
  parameter int T_WPH_NS = 30,
  parameter int T_WC_NS = 100,
  parameter int T_RC_NS = 100,
  parameter int T_OE_NS = 40,
  parameter int T_DF_NS = 30,
  parameter int unsigned PROG_TMO_CYC = 40000,
  parameter int unsigned ERASE_TMO_CYC = 1875000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  localparam int WP_CYC  = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int WPH_CYC = (T_WPH_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC_CYC  = (T_WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WH_CYC  = (WPH_CYC > WC_CYC - WP_CYC) ? WPH_CYC : WC_CYC - WP_CYC;
  localparam int RC_CYC  = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE_CYC  = (T_OE_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam int RD_CYC  = (RC_CYC > OE_CYC) ? RC_CYC : OE_CYC;
  localparam int DF_CYC  = (T_DF_NS + CLK_NS - 1) / CLK_NS;
  localparam int GAP_CYC = (DF_CYC > 1) ? DF_CYC : 1;
  localparam int PH_MAX  = (WP_CYC > WH_CYC ? (WP_CYC > RD_CYC ? WP_CYC : RD_CYC)
                                            : (WH_CYC > RD_CYC ? WH_CYC : RD_CYC));
  localparam int CNT_W   = $clog2(PH_MAX + 1);
  localparam int unsigned TMO_MAX = (PROG_TMO_CYC > ERASE_TMO_CYC) ? PROG_TMO_CYC : ERASE_TMO_CYC;
  localparam int TMO_W   = $clog2(TMO_MAX) + 1;

  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_PROG = 2'd1;
  localparam logic [1:0] OP_CHIP = 2'd3;

  localparam logic [ADDR_W-1:0] A_UNL1 = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] A_UNL2 = ADDR_W'(12'h2AA);

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RLO, S_RHI} st_t;
  typedef enum logic [2:0] {K_CMD, K_POLL, K_FINAL, K_ABORT, K_READ} kind_t;

  st_t                st;
  kind_t              kind;
  logic [CNT_W-1:0]   ph_cnt;
  logic [2:0]         step;
  logic [1:0]         op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         data_q;
  logic [7:0]         samp;
  logic               prev6;
  logic               have_prev;
  logic [TMO_W-1:0]   tmo_cnt;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [7:0]         cmd_data;

  wire is_prog  = (op_q == OP_PROG);
  wire [2:0] last_step = is_prog ? 3'd3 : 3'd5;
  wire [TMO_W-1:0] tmo_lim = is_prog ? TMO_W'(PROG_TMO_CYC) : TMO_W'(ERASE_TMO_CYC);
  wire tmo_hit  = (tmo_cnt >= tmo_lim);
  wire [7:0] expect_byte = is_prog ? data_q : 8'hFF;
  wire ph_end   = (ph_cnt == '0);

  always_comb begin
    case (step)
      3'd0: begin cmd_addr = A_UNL1; cmd_data = 8'hAA; end
      3'd1: begin cmd_addr = A_UNL2; cmd_data = 8'h55; end
      3'd2: begin cmd_addr = A_UNL1; cmd_data = is_prog ? 8'hA0 : 8'h80; end
      3'd3: begin
        cmd_addr = is_prog ? addr_q : A_UNL1;
        cmd_data = is_prog ? data_q : 8'hAA;
      end
      3'd4: begin cmd_addr = A_UNL2; cmd_data = 8'h55; end
      default: begin
        cmd_addr = (op_q == OP_CHIP) ? A_UNL1 : addr_q;
        cmd_data = (op_q == OP_CHIP) ? 8'h10 : 8'h30;
      end
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign fl_ce_n   = (st == S_IDLE);
  assign fl_we_n   = (st != S_WLO);
  assign fl_oe_n   = (st != S_RLO);
  assign fl_dq_oe  = (st == S_WLO) || (st == S_WHI);
  assign fl_dq_out = (kind == K_ABORT) ? 8'hF0 : cmd_data;
  assign fl_addr   = (st == S_RLO || st == S_RHI) ? addr_q :
                     (kind == K_ABORT) ? '0 : cmd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind      <= K_CMD;
      ph_cnt    <= '0;
      step      <= '0;
      op_q      <= OP_READ;
      addr_q    <= '0;
      data_q    <= '0;
      samp      <= '0;
      prev6     <= 1'b0;
      have_prev <= 1'b0;
      tmo_cnt   <= '0;
      rd_data   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (kind == K_POLL && !tmo_hit) tmo_cnt <= tmo_cnt + 1'b1;
      case (st)
        S_IDLE: if (req_start) begin
          op_q   <= req_op;
          addr_q <= req_addr;
          data_q <= req_data;
          step   <= '0;
          err    <= 1'b0;
          if (req_op == OP_READ) begin
            kind   <= K_READ;
            st     <= S_RLO;
            ph_cnt <= CNT_W'(RD_CYC - 1);
          end else begin
            kind   <= K_CMD;
            st     <= S_WLO;
            ph_cnt <= CNT_W'(WP_CYC - 1);
          end
        end
        S_WLO: begin
          if (ph_end) begin
            st     <= S_WHI;
            ph_cnt <= CNT_W'(WH_CYC - 1);
          end else ph_cnt <= ph_cnt - 1'b1;
        end
        S_WHI: begin
          if (!ph_end) ph_cnt <= ph_cnt - 1'b1;
          else if (kind == K_ABORT) begin
            st   <= S_IDLE;
            done <= 1'b1;
            err  <= 1'b1;
          end else if (step == last_step) begin
            kind      <= K_POLL;
            have_prev <= 1'b0;
            tmo_cnt   <= '0;
            st        <= S_RLO;
            ph_cnt    <= CNT_W'(RD_CYC - 1);
          end else begin
            step   <= step + 1'b1;
            st     <= S_WLO;
            ph_cnt <= CNT_W'(WP_CYC - 1);
          end
        end
        S_RLO: begin
          if (ph_end) begin
            samp   <= fl_dq_in;
            st     <= S_RHI;
            ph_cnt <= CNT_W'(GAP_CYC - 1);
          end else ph_cnt <= ph_cnt - 1'b1;
        end
        S_RHI: begin
          if (!ph_end) ph_cnt <= ph_cnt - 1'b1;
          else begin
            case (kind)
              K_POLL: begin
                if (have_prev && prev6 == samp[6]) begin
                  kind   <= K_FINAL;
                  st     <= S_RLO;
                  ph_cnt <= CNT_W'(RD_CYC - 1);
                end else if (tmo_hit) begin
                  kind   <= K_ABORT;
                  st     <= S_WLO;
                  ph_cnt <= CNT_W'(WP_CYC - 1);
                end else begin
                  prev6     <= samp[6];
                  have_prev <= 1'b1;
                  st        <= S_RLO;
                  ph_cnt    <= CNT_W'(RD_CYC - 1);
                end
              end
              K_FINAL: begin
                rd_data <= samp;
                err     <= (samp != expect_byte);
                done    <= 1'b1;
                st      <= S_IDLE;
              end
              default: begin
                rd_data <= samp;
                done    <= 1'b1;
                st      <= S_IDLE;
              end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  localparam int MW = CNT_W + 2;
  logic [MW-1:0] we_lo_len, we_hi_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_lo_len <= '0;
      we_hi_len <= '0;
    end else begin
      we_lo_len <= fl_we_n ? '0 : ((&we_lo_len) ? we_lo_len : we_lo_len + 1'b1);
      we_hi_len <= !fl_we_n ? '0 : ((&we_hi_len) ? we_hi_len : we_hi_len + 1'b1);
    end
  end

  p_no_oe_during_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));
  p_drive_during_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_dq_oe);
  p_bus_stable_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
  p_we_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (we_lo_len >= MW'(WP_CYC)));
  p_we_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> (we_hi_len >= MW'(WPH_CYC)));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_start) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int AW = 21;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          req_start;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  wire           busy, done, err, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
  wire [7:0]     rd_data, fl_dq_out, fl_dq_in;
  wire [AW-1:0]  fl_addr;

  flash_cmd_seq #(.ADDR_W(AW), .PROG_TMO_CYC(3000), .ERASE_TMO_CYC(8000)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n));

  // flash model
  logic [7:0]    mem [16];
  logic [AW-1:0] wa [8];
  logic [7:0]    wd [8];
  int nw = 0, busy_reads = 0, pend_reads = 0;
  bit stuck = 0, pend_stuck = 0, pend_inj = 0, tog = 0;

  always @(posedge fl_we_n) begin
    if (fl_ce_n === 1'b0) begin
      if (nw < 8) begin wa[nw] = fl_addr; wd[nw] = fl_dq_out; end
      nw++;
      if (fl_dq_out == 8'hF0) begin busy_reads = 0; stuck = 0; end
      else if (nw == 4 && wd[2] == 8'hA0) begin
        mem[fl_addr[3:0]] = (mem[fl_addr[3:0]] & fl_dq_out) ^ {7'b0, pend_inj};
        busy_reads = pend_reads; stuck = pend_stuck;
      end else if (nw == 6 && wd[2] == 8'h80 && (fl_dq_out == 8'h10 || fl_dq_out == 8'h30)) begin
        for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
        busy_reads = pend_reads; stuck = pend_stuck;
      end
    end
  end

  always @(negedge fl_oe_n) begin
    if (stuck) tog = ~tog;
    else if (busy_reads > 0) begin tog = ~tog; busy_reads--; end
  end

  assign fl_dq_in = (stuck || busy_reads > 0) ? {1'b0, tog, 6'h00} : mem[fl_addr[3:0]];

  // checking
  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus timing monitor, sampled on the falling clock edge
  int lo_run = 0, hi_run = 0, wc_run = 0, oe_run = 0;
  int min_lo = 9999, min_hi = 9999, min_wc = 9999, min_oe = 9999;
  int overlap = 0, drive_bad = 0, unstable = 0;
  bit prev_we = 1, prev_oe = 1, seen = 0;
  logic [AW-1:0] prev_a;
  logic [7:0] prev_d;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (!fl_we_n && !fl_oe_n) overlap++;
      if (!fl_we_n && !fl_dq_oe) drive_bad++;
      if (!fl_we_n && !prev_we && (fl_addr != prev_a || fl_dq_out != prev_d)) unstable++;
      if (!fl_we_n) begin
        if (prev_we) begin
          if (seen) begin
            if (hi_run < min_hi) min_hi = hi_run;
            if (wc_run < min_wc) min_wc = wc_run;
          end
          seen = 1; wc_run = 0;
        end
        lo_run++; hi_run = 0;
      end else begin
        if (!prev_we) begin
          if (lo_run < min_lo) min_lo = lo_run;
          lo_run = 0;
        end
        hi_run++;
      end
      wc_run++;
      if (!fl_oe_n) oe_run++;
      else begin
        if (!prev_oe && oe_run < min_oe) min_oe = oe_run;
        oe_run = 0;
      end
      if (fl_ce_n) seen = 0;
      prev_we = fl_we_n; prev_oe = fl_oe_n; prev_a = fl_addr; prev_d = fl_dq_out;
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc++;

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R8 actual=no_done expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [AW+7:0] exp_wr(input logic [1:0] op, input int i,
                                           input logic [AW-1:0] a, input logic [7:0] d);
    logic [AW-1:0] u1, u2;
    u1 = AW'(12'h555); u2 = AW'(12'h2AA);
    case (i)
      0: return {u1, 8'hAA};
      1: return {u2, 8'h55};
      2: return {u1, (op == 2'd1) ? 8'hA0 : 8'h80};
      3: return (op == 2'd1) ? {a, d} : {u1, 8'hAA};
      4: return {u2, 8'h55};
      default: return (op == 2'd3) ? {u1, 8'h10} : {a, 8'h30};
    endcase
  endfunction

  task automatic run_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                         input int reads, input bit stk, input bit inj,
                         output bit e, output logic [7:0] r, output int dw, output int el);
    int t0;
    @(negedge clk);
    pend_reads = reads; pend_stuck = stk; pend_inj = inj; nw = 0;
    req_op = op; req_addr = a; req_data = d; req_start = 1'b1;
    t0 = cyc;
    @(negedge clk);
    req_start = 1'b0;
    while (!done) @(negedge clk);
    el = cyc - t0;
    e = err; r = rd_data; dw = 0;
    while (done) begin dw++; @(negedge clk); end
  endtask

  // op, addr, data, status reads, inject, expected err, expected byte
  localparam logic [56:0] VEC [10] = '{
    {2'd0, 21'h000003, 8'h00, 16'd0,   1'b0, 1'b0, 8'h3C},
    {2'd1, 21'h000005, 8'hA7, 16'd6,   1'b0, 1'b0, 8'hA7},
    {2'd0, 21'h000005, 8'h00, 16'd0,   1'b0, 1'b0, 8'hA7},
    {2'd1, 21'h000003, 8'h0F, 16'd3,   1'b0, 1'b1, 8'h0C},
    {2'd2, 21'h1F0006, 8'h00, 16'd40,  1'b0, 1'b0, 8'hFF},
    {2'd0, 21'h000003, 8'h00, 16'd0,   1'b0, 1'b0, 8'hFF},
    {2'd1, 21'h000009, 8'h12, 16'd5,   1'b1, 1'b1, 8'h13},
    {2'd3, 21'h000000, 8'h00, 16'd150, 1'b0, 1'b0, 8'hFF},
    {2'd1, 21'h000002, 8'h55, 16'd0,   1'b0, 1'b0, 8'h55},
    {2'd2, 21'h0A000B, 8'h00, 16'd200, 1'b0, 1'b0, 8'hFF}
  };

  initial begin
    bit e;
    logic [7:0] r;
    int dw, el, ndone;
    for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
    mem[3] = 8'h3C;
    rst_n = 1'b0; req_start = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R9 strobes idle high", {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
    chk(!fl_dq_oe, "R9 drive off", fl_dq_oe, 0);
    chk(!busy && !done, "R9 busy/done low", {busy, done}, 0);

    for (int v = 0; v < 10; v++) begin
      logic [1:0] op;
      logic [AW-1:0] a;
      logic [7:0] d;
      int expn;
      op = VEC[v][56:55]; a = VEC[v][54:34]; d = VEC[v][33:26];
      run_req(op, a, d, int'(VEC[v][25:10]), 1'b0, VEC[v][9], e, r, dw, el);
      expn = (op == 2'd0) ? 0 : (op == 2'd1) ? 4 : 6;
      chk(nw == expn, (op == 2'd0) ? "R7 no writes on read" : (op == 2'd1) ? "R1 write count" : "R2 write count", nw, expn);
      for (int k = 0; k < expn && k < nw; k++)
        chk({wa[k], wd[k]} == exp_wr(op, k, a, d), (op == 2'd1) ? "R1 write cycle" : "R2 write cycle",
            {wa[k], wd[k]}, exp_wr(op, k, a, d));
      chk(e == VEC[v][8], (op == 2'd0) ? "R7 err clear" : "R5 verify err", e, VEC[v][8]);
      chk(r == VEC[v][7:0], (op == 2'd0) ? "R7 read byte" : "R5 final byte", r, VEC[v][7:0]);
      chk(dw == 1, "R8 done one clock", dw, 1);
    end
    // vector 9 erase polled longer than the program limit yet succeeded: R6 separate limits

    // R6 program timeout
    run_req(2'd1, 21'h000004, 8'h11, 0, 1'b1, 1'b0, e, r, dw, el);
    chk(e, "R6 program timeout err", e, 1);
    chk(nw == 5, "R6 program abort write count", nw, 5);
    chk(wd[4] == 8'hF0, "R6 program abort byte", wd[4], 8'hF0);
    chk(el >= 3000, "R6 program limit respected", el, 3000);
    chk(el < 8000, "R6 program limit not erase limit", el, 8000);

    // R6 erase timeout
    run_req(2'd2, 21'h100000, 8'h00, 0, 1'b1, 1'b0, e, r, dw, el);
    chk(e, "R6 erase timeout err", e, 1);
    chk(nw == 7, "R6 erase abort write count", nw, 7);
    chk(wd[6] == 8'hF0, "R6 erase abort byte", wd[6], 8'hF0);
    chk(el >= 8000, "R6 erase limit respected", el, 8000);

    // R8 start ignored while busy
    @(negedge clk);
    pend_reads = 20; pend_stuck = 0; pend_inj = 0; nw = 0;
    req_op = 2'd1; req_addr = 21'h000004; req_data = 8'h66; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(busy, "R8 busy after start", busy, 1);
    repeat (30) @(negedge clk);
    req_op = 2'd3; req_addr = 21'h000007; req_data = 8'h00; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    while (!done) @(negedge clk);
    chk(nw == 4, "R8 second start ignored", nw, 4);
    chk(rd_data == 8'h66 && !err, "R8 first request result", {err, rd_data}, 9'h066);
    @(negedge clk);
    chk(!busy, "R8 busy clear after done", busy, 0);
    ndone = 0;
    repeat (300) begin @(negedge clk); if (done) ndone++; end
    chk(ndone == 0 && nw == 4, "R8 no extra request", ndone, 0);

    // R3/R4 bus timing over the whole run
    chk(min_lo * 8 >= 50, "R3 strobe low width ns", min_lo * 8, 50);
    chk(min_hi * 8 >= 30, "R3 strobe high width ns", min_hi * 8, 30);
    chk(min_wc * 8 >= 100, "R3 write cycle ns", min_wc * 8, 100);
    chk(unstable == 0, "R3 bus stable while strobe low", unstable, 0);
    chk(overlap == 0, "R4 no output enable during strobe", overlap, 0);
    chk(drive_bad == 0, "R4 drive during strobe", drive_bad, 0);
    chk(min_oe * 8 >= 100, "R7 read cycle ns", min_oe * 8, 100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule